// File: doc/BRIEF.md
# Full Memory Barrier Sequencer

This block carries out a full memory barrier in an out-of-order core. A barrier instruction that reaches the register-map stage raises `mbValid` for one cycle. The sequencer then holds the map stage, and every younger instruction behind it, until the barrier is complete. It first waits for the instruction queue to empty. Next it pulses a request that pushes all pending miss requests and buffered I/O writes out to the system port. It then waits for a completion point and pulses a mark on the youngest probe-queue entry. The last step waits for the memory queues to drain and for the response to that marked probe to leave. Only then does it release the stall.

The completion point depends on a mode bit, which is sampled when the barrier is accepted. With the bit clear, the sequencer keeps its own saturating count of outstanding committed events. It reaches the completion point when that count steps from one to zero, or at once if the count is already zero. With the bit set, it sends an explicit barrier command to the system and waits for the acknowledge. Barriers run speculatively, so a kill may abandon one at any point. A command that has already gone out still owes an acknowledge. That late acknowledge is absorbed and does not complete a later barrier.

Top module: `fullBarrierSeq`

## Requirements
- R1: Out of reset `mapStall`, `flushReq`, `sysBarrierCmd` and `probeMark` are all 0.
- R2: In the cycle after an idle sequencer sees `mbValid` with `kill` low, `mapStall` is 1. It stays 1 until release or kill.
- R3: `flushReq` is a one-cycle pulse. It appears in the cycle after the first cycle in which `iqEmpty` is sampled 1 after acceptance, and never earlier.
- R4: With the mode bit 0, `sysBarrierCmd` stays 0. `probeMark` pulses in the cycle after an `evtDecr` without `evtIncr` that takes the event count from 1 to 0. The event count rises by one on `evtIncr` alone, falls by one on `evtDecr` alone, and saturates at 0 and at 15.
- R5: With the mode bit 0 and the event count already 0, `probeMark` pulses two cycles after the `flushReq` pulse.
- R6: With the mode bit 1, `sysBarrierCmd` pulses in the cycle after `flushReq`. `probeMark` pulses in the cycle after `sysAck` is sampled 1 while the command is awaited.
- R7: `probeMark` is 1 for exactly one cycle per completed barrier, and is 0 whenever no barrier is in progress.
- R8: After the mark, `mapStall` falls in the cycle after a cycle in which `missDstreamEmpty`, `storeQEmpty`, `loadQEmpty` and `ioWbEmpty` are all 1 and `probeRespSent` is 1 in that cycle or has been seen since the mark. Until then `mapStall` stays 1.
- R9: `kill` with a barrier in progress drops `mapStall` in the next cycle. Nothing further is marked for that barrier. `kill` together with `mbValid` on an idle sequencer is not accepted.
- R10: After a killed command that is still unacknowledged, a later barrier in mode 1 holds `sysBarrierCmd` at 0 until the owed `sysAck` arrives. That acknowledge produces no mark. The command goes out in the cycle after it.
- R11: The mode bit is sampled only on acceptance. Changes to `mbMode` during a barrier have no effect on its path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mbValid | input | 1 | Barrier arrived at map stage (one-cycle pulse) |
| mbMode | input | 1 | Completion mode: 0 event count, 1 system command |
| kill | input | 1 | Abandon the barrier in progress |
| iqEmpty | input | 1 | Instruction queue empty |
| evtIncr | input | 1 | One more outstanding committed event |
| evtDecr | input | 1 | One outstanding committed event retired |
| sysAck | input | 1 | System acknowledge of barrier command |
| missDstreamEmpty | input | 1 | Miss queue holds no data-stream references |
| storeQEmpty | input | 1 | Store queue empty |
| loadQEmpty | input | 1 | Load queue empty |
| ioWbEmpty | input | 1 | I/O write buffer empty |
| probeRespSent | input | 1 | Response for the marked probe has been sent |
| mapStall | output | 1 | Hold the map stage and younger instructions |
| flushReq | output | 1 | Push pending miss and I/O write entries to the system port |
| sysBarrierCmd | output | 1 | Barrier command to the system port |
| probeMark | output | 1 | Mark the youngest probe-queue entry |

## Verification
The assertions assume that `mbValid` arrives only while the sequencer is idle. They also assume that `sysAck` arrives only against a command that was actually sent, and at most once per command. The bench keeps to both. It raises `mbValid` only after `mapStall` has fallen, and pulses `sysAck` only while a command is owed: either during the wait for it, or as the late reply to a killed command. The sweep covers every combination of mode, instruction-queue delay, starting event count and drain delay. In each run the bench drives `mbMode` to the opposite value right after acceptance, and places the probe response either before the queues empty or in the same cycle.

// File: rtl/fbsPkg.sv
package fbsPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_IQ,
    ST_FLUSH,
    ST_WAIT_CNT,
    ST_SEND_CMD,
    ST_WAIT_ACK,
    ST_MARK,
    ST_DRAIN
  } seqStateT;

  typedef struct packed {
    logic accept;
    logic issueCmd;
    logic inDrain;
  } ctrlStrobeT;

endpackage

// File: rtl/fullBarrierDp.sv
module fullBarrierDp
  import fbsPkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctrlStrobeT strb,
  input  logic       busyIn,
  input  logic       mbMode,
  input  logic       evtIncr,
  input  logic       evtDecr,
  input  logic       sysAck,
  input  logic       missDstreamEmpty,
  input  logic       storeQEmpty,
  input  logic       loadQEmpty,
  input  logic       ioWbEmpty,
  input  logic       probeRespSent,
  output logic       modeQ,
  output logic       ackOwed,
  output logic       ackHit,
  output logic       cntReady,
  output logic       drainDone
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cntQ;
  logic             respSeenQ;
  logic             upOnly;
  logic             downOnly;
  logic             zeroStep;
  logic             queuesIdle;

  assign upOnly   = evtIncr & ~evtDecr;
  assign downOnly = evtDecr & ~evtIncr;
  assign zeroStep = downOnly & (cntQ == CNT_ONE);
  assign cntReady = zeroStep | (cntQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (upOnly && cntQ != CNT_MAX) begin
      cntQ <= cntQ + CNT_ONE;
    end else if (downOnly && cntQ != '0) begin
      cntQ <= cntQ - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= 1'b0;
    end else if (strb.accept) begin
      modeQ <= mbMode;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackOwed <= 1'b0;
    end else if (strb.issueCmd) begin
      ackOwed <= 1'b1;
    end else if (sysAck) begin
      ackOwed <= 1'b0;
    end
  end

  assign ackHit = sysAck & ackOwed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respSeenQ <= 1'b0;
    end else if (!strb.inDrain) begin
      respSeenQ <= 1'b0;
    end else if (probeRespSent) begin
      respSeenQ <= 1'b1;
    end
  end

  assign queuesIdle = missDstreamEmpty & storeQEmpty & loadQEmpty & ioWbEmpty;
  assign drainDone  = queuesIdle & (respSeenQ | probeRespSent);

  AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ == '0 && downOnly) |=> (cntQ == '0)); // R4

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busyIn && $past(busyIn)) |-> $stable(modeQ)); // R11

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (sysAck && !strb.issueCmd) |=> !ackOwed); // R10

endmodule

// File: rtl/fullBarrierCtrl.sv
module fullBarrierCtrl
  import fbsPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       mbValid,
  input  logic       kill,
  input  logic       iqEmpty,
  input  logic       modeQ,
  input  logic       ackOwed,
  input  logic       ackHit,
  input  logic       cntReady,
  input  logic       drainDone,
  output ctrlStrobeT strb,
  output logic       busy,
  output logic       mapStall,
  output logic       flushReq,
  output logic       sysBarrierCmd,
  output logic       probeMark
);

  seqStateT stateQ;
  seqStateT stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
    end else begin
      stateQ <= stateD;
    end
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:     if (mbValid) stateD = ST_WAIT_IQ;
      ST_WAIT_IQ:  if (iqEmpty) stateD = ST_FLUSH;
      ST_FLUSH:    stateD = modeQ ? ST_SEND_CMD : ST_WAIT_CNT;
      ST_WAIT_CNT: if (cntReady) stateD = ST_MARK;
      ST_SEND_CMD: if (!ackOwed) stateD = ST_WAIT_ACK;
      ST_WAIT_ACK: if (ackHit) stateD = ST_MARK;
      ST_MARK:     stateD = ST_DRAIN;
      ST_DRAIN:    if (drainDone) stateD = ST_IDLE;
      default:     stateD = ST_IDLE;
    endcase
    if (kill) stateD = ST_IDLE;
  end

  assign busy          = (stateQ != ST_IDLE);
  assign mapStall      = busy;
  assign flushReq      = (stateQ == ST_FLUSH);
  assign probeMark     = (stateQ == ST_MARK);
  assign strb.accept   = (stateQ == ST_IDLE) & mbValid & ~kill;
  assign strb.issueCmd = (stateQ == ST_SEND_CMD) & ~ackOwed;
  assign strb.inDrain  = (stateQ == ST_DRAIN);
  assign sysBarrierCmd = strb.issueCmd;

  AST_STALL_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && mbValid && !kill) |=> mapStall); // R2

  AST_FLUSH_AFTER_IQ: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |-> $past(iqEmpty)); // R3

  AST_MARK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    probeMark |=> !probeMark); // R7

  AST_CMD_NOT_OWED: assert property (@(posedge clk) disable iff (!rstN)
    sysBarrierCmd |-> !ackOwed); // R10

  AST_RELEASE_COND: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mapStall) |-> ($past(kill) || $past(drainDone))); // R8

  AST_KILL_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    kill |=> !mapStall); // R9

  AST_NO_CMD_MODE0: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !modeQ) |-> !sysBarrierCmd); // R4

endmodule

// File: rtl/fullBarrierSeq.sv
module fullBarrierSeq
  import fbsPkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic mbValid,
  input  logic mbMode,
  input  logic kill,
  input  logic iqEmpty,
  input  logic evtIncr,
  input  logic evtDecr,
  input  logic sysAck,
  input  logic missDstreamEmpty,
  input  logic storeQEmpty,
  input  logic loadQEmpty,
  input  logic ioWbEmpty,
  input  logic probeRespSent,
  output logic mapStall,
  output logic flushReq,
  output logic sysBarrierCmd,
  output logic probeMark
);

  ctrlStrobeT strb;
  logic       busy;
  logic       modeQ;
  logic       ackOwed;
  logic       ackHit;
  logic       cntReady;
  logic       drainDone;

  fullBarrierCtrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .mbValid       (mbValid),
    .kill          (kill),
    .iqEmpty       (iqEmpty),
    .modeQ         (modeQ),
    .ackOwed       (ackOwed),
    .ackHit        (ackHit),
    .cntReady      (cntReady),
    .drainDone     (drainDone),
    .strb          (strb),
    .busy          (busy),
    .mapStall      (mapStall),
    .flushReq      (flushReq),
    .sysBarrierCmd (sysBarrierCmd),
    .probeMark     (probeMark)
  );

  fullBarrierDp #(
    .CNT_W (CNT_W)
  ) u_dp (
    .clk              (clk),
    .rstN             (rstN),
    .strb             (strb),
    .busyIn           (busy),
    .mbMode           (mbMode),
    .evtIncr          (evtIncr),
    .evtDecr          (evtDecr),
    .sysAck           (sysAck),
    .missDstreamEmpty (missDstreamEmpty),
    .storeQEmpty      (storeQEmpty),
    .loadQEmpty       (loadQEmpty),
    .ioWbEmpty        (ioWbEmpty),
    .probeRespSent    (probeRespSent),
    .modeQ            (modeQ),
    .ackOwed          (ackOwed),
    .ackHit           (ackHit),
    .cntReady         (cntReady),
    .drainDone        (drainDone)
  );

endmodule

// File: tb/fullBarrierSeq_tb.sv
module fullBarrierSeq_tb;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mbValid = 1'b0;
  logic mbMode = 1'b0;
  logic kill = 1'b0;
  logic iqEmpty = 1'b0;
  logic evtIncr = 1'b0;
  logic evtDecr = 1'b0;
  logic sysAck = 1'b0;
  logic missDstreamEmpty = 1'b0;
  logic storeQEmpty = 1'b0;
  logic loadQEmpty = 1'b0;
  logic ioWbEmpty = 1'b0;
  logic probeRespSent = 1'b0;
  logic mapStall;
  logic flushReq;
  logic sysBarrierCmd;
  logic probeMark;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fullBarrierSeq u_dut (
    .clk              (clk),
    .rstN             (rstN),
    .mbValid          (mbValid),
    .mbMode           (mbMode),
    .kill             (kill),
    .iqEmpty          (iqEmpty),
    .evtIncr          (evtIncr),
    .evtDecr          (evtDecr),
    .sysAck           (sysAck),
    .missDstreamEmpty (missDstreamEmpty),
    .storeQEmpty      (storeQEmpty),
    .loadQEmpty       (loadQEmpty),
    .ioWbEmpty        (ioWbEmpty),
    .probeRespSent    (probeRespSent),
    .mapStall         (mapStall),
    .flushReq         (flushReq),
    .sysBarrierCmd    (sysBarrierCmd),
    .probeMark        (probeMark)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic setQueues(logic v);
    missDstreamEmpty = v;
    storeQEmpty = v;
    loadQEmpty = v;
    ioWbEmpty = v;
  endtask

  task automatic loadCount(int n);
    for (int i = 0; i < n; i++) begin
      evtIncr = 1'b1;
      step();
    end
    evtIncr = 1'b0;
  endtask

  // Accept a barrier and reach the flush pulse.
  task automatic startBarrier(logic mode, int iqDly);
    iqEmpty = 1'b0;
    mbMode = mode;
    mbValid = 1'b1;
    step();
    mbValid = 1'b0;
    mbMode = ~mode; // R11: ignored after acceptance
    check("R2", "stall after accept", mapStall, 1'b1);
    for (int i = 0; i < iqDly; i++) begin
      check("R3", "no early flush", flushReq, 1'b0);
      step();
    end
    iqEmpty = 1'b1;
    check("R3", "no flush before iq", flushReq, 1'b0);
    step();
    check("R3", "flush pulse", flushReq, 1'b1);
    check("R6", "no cmd at flush", sysBarrierCmd, 1'b0);
    step();
    check("R3", "flush single", flushReq, 1'b0);
  endtask

  task automatic finishDrain(int drnDly);
    step();
    check("R7", "mark one cycle", probeMark, 1'b0);
    check("R8", "stall in drain", mapStall, 1'b1);
    for (int d = 0; d < drnDly; d++) begin
      probeRespSent = (d == 0);
      step();
      probeRespSent = 1'b0;
      check("R8", "stall held while busy queues", mapStall, 1'b1);
      check("R7", "no second mark", probeMark, 1'b0);
    end
    setQueues(1'b1);
    probeRespSent = (drnDly == 0);
    step();
    probeRespSent = 1'b0;
    check("R8", "release", mapStall, 1'b0);
    check("R7", "mark idle", probeMark, 1'b0);
    setQueues(1'b0);
  endtask

  task automatic runBarrier(logic mode, int iqDly, int cntInit, int drnDly);
    setQueues(1'b0);
    loadCount(mode ? 0 : cntInit);
    startBarrier(mode, iqDly);
    if (!mode) begin
      check("R4", "no cmd in mode 0", sysBarrierCmd, 1'b0);
      check("R11", "mode held", sysBarrierCmd, 1'b0);
      if (cntInit == 0) begin
        step();
        check("R5", "mark with zero count", probeMark, 1'b1);
      end else begin
        for (int k = 0; k < cntInit; k++) begin
          check("R4", "no early mark", probeMark, 1'b0);
          evtDecr = 1'b1;
          step();
          evtDecr = 1'b0;
        end
        check("R4", "mark on one to zero", probeMark, 1'b1);
      end
    end else begin
      check("R6", "cmd after flush", sysBarrierCmd, 1'b1);
      check("R11", "mode held", sysBarrierCmd, 1'b1);
      step();
      check("R6", "cmd single", sysBarrierCmd, 1'b0);
      for (int a = 0; a < cntInit; a++) begin
        check("R6", "no mark before ack", probeMark, 1'b0);
        step();
      end
      sysAck = 1'b1;
      step();
      sysAck = 1'b0;
      check("R6", "mark after ack", probeMark, 1'b1);
    end
    finishDrain(drnDly);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3);
    check("R1", "reset stall", mapStall, 1'b0);
    check("R1", "reset flush", flushReq, 1'b0);
    check("R1", "reset cmd", sysBarrierCmd, 1'b0);
    check("R1", "reset mark", probeMark, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    step();
    check("R1", "idle stall", mapStall, 1'b0);

    // Sweep mode, iq delay, count / ack delay, drain delay.
    for (int m = 0; m < 2; m++)
      for (int q = 0; q < 3; q++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 3; d++)
            runBarrier(m[0], q, c, d);

    // R9: kill together with mbValid while idle is not accepted.
    mbValid = 1'b1;
    kill = 1'b1;
    step();
    mbValid = 1'b0;
    kill = 1'b0;
    check("R9", "kill blocks accept", mapStall, 1'b0);

    // R9: kill during count wait in mode 0.
    loadCount(2);
    startBarrier(1'b0, 0);
    kill = 1'b1;
    step();
    kill = 1'b0;
    check("R9", "stall dropped on kill", mapStall, 1'b0);
    for (int k = 0; k < 2; k++) begin
      evtDecr = 1'b1;
      step();
      evtDecr = 1'b0;
      check("R7", "no mark after kill", probeMark, 1'b0);
    end
    step();
    check("R7", "no mark idle", probeMark, 1'b0);

    // R4: saturation at zero, then single increment gives one-to-zero mark.
    evtDecr = 1'b1;
    step();
    step();
    evtDecr = 1'b0;
    loadCount(1);
    startBarrier(1'b0, 1);
    evtDecr = 1'b1;
    step();
    evtDecr = 1'b0;
    check("R4", "floor then one step", probeMark, 1'b1);
    finishDrain(1);

    // R10: kill with command outstanding, then a new barrier.
    startBarrier(1'b1, 0);
    check("R6", "cmd sent", sysBarrierCmd, 1'b1);
    step();
    kill = 1'b1;
    step();
    kill = 1'b0;
    check("R9", "kill in ack wait", mapStall, 1'b0);
    startBarrier(1'b1, 1);
    for (int w = 0; w < 3; w++) begin
      check("R10", "cmd withheld", sysBarrierCmd, 1'b0);
      check("R10", "stall held", mapStall, 1'b1);
      step();
    end
    sysAck = 1'b1;
    step();
    sysAck = 1'b0;
    check("R10", "stale ack gives no mark", probeMark, 1'b0);
    check("R10", "cmd after stale ack", sysBarrierCmd, 1'b1);
    step();
    check("R10", "no mark before fresh ack", probeMark, 1'b0);
    sysAck = 1'b1;
    step();
    sysAck = 1'b0;
    check("R10", "mark after fresh ack", probeMark, 1'b1);
    finishDrain(2);

    // R8: response seen before queues empty is remembered; queues partly empty hold stall.
    startBarrier(1'b0, 0);
    step();
    check("R5", "zero count mark", probeMark, 1'b1);
    step();
    probeRespSent = 1'b1;
    missDstreamEmpty = 1'b1;
    storeQEmpty = 1'b1;
    loadQEmpty = 1'b1;
    step();
    probeRespSent = 1'b0;
    check("R8", "io queue busy holds stall", mapStall, 1'b1);
    ioWbEmpty = 1'b1;
    step();
    check("R8", "release on remembered response", mapStall, 1'b0);
    setQueues(1'b0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule